// File: doc/BRIEF.md
# Programmable Two-Digit Frequency Divider

This block divides its clock by a programmable ratio N and marks each period with a one-cycle terminal pulse. The count is held in two 4-bit down-counting digits. The low digit steps down on every rising clock edge. The high digit steps down whenever the low digit wraps from zero. Each digit has its own mode select, so it counts either in plain binary (sixteen states) or in decimal (ten states). The ratio is therefore `N = high * M_low + low`, where `M_low` is the modulus of the low digit.

The preset is loaded automatically in the cycle that follows the count reaching one. No external load strobe is needed, and the output frequency follows the preset from the next period onward. Two conditions select the largest ratio for the current pair of modes, which is the product of the two digit moduli:

- an all-zero preset;
- a low level on the chain-enable input, which also makes the preset a don't-care.

Another counter can take the top bit of the high digit from the second output. That bit toggles only when the high digit reaches its upper half.

Top module: `divn_counter`

## Requirements
- R1: Each rising clock edge decrements the two-digit count by one, with a borrow from the low digit into the high digit. With a preset of `high:low` (high digit in `preset[7:4]`, low digit in `preset[3:0]`), `zero_pulse` recurs every `high * M_low + low` clocks.
- R2: A digit whose `digit_dec` bit is 1 counts in decimal (modulus 10, wrapping 0 to 9). A digit whose bit is 0 counts in binary (modulus 16, wrapping 0 to 15). Bit 0 selects the mode of the low digit and bit 1 selects the mode of the high digit.
- R3: `zero_pulse` is a registered output. It is high for exactly one clock, during the cycle in which the count equals one, and low in every other cycle. The preset is reloaded at the next edge.
- R4: A preset of all zeros gives the maximum ratio for the mode pair: 256 (both binary), 160 (one binary, one decimal) or 100 (both decimal).
- R5: While `cascade_en` is 0, the preset value has no effect and the ratio is the maximum of R4 for the current modes.
- R6: `msb_out` is bit 3 of the high digit. It is never high in a period whose preset has that bit clear and whose ratio is not the maximum.
- R7: In decimal mode, a preset digit above 9 loads as 9.
- R8: Synchronous active-high `rst` loads the current preset (or the maximum) and holds `zero_pulse` low. The first pulse follows N-1 clocks after `rst` falls.
- R9: The smallest supported ratio is 2. With both digits binary, the largest programmed ratio is 255. A preset of 1 is not supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; loads the preset |
| preset | input | 8 | Divide ratio: high digit in [7:4], low digit in [3:0] |
| digit_dec | input | 2 | Per-digit mode, 1 = decimal, 0 = binary; bit 0 low digit |
| cascade_en | input | 1 | 1 = use preset; 0 = ignore preset, maximum ratio |
| zero_pulse | output | 1 | One-cycle pulse while the count equals one |
| msb_out | output | 1 | Top bit of the high digit |

## Verification
The bench builds the block with its default parameters: two digits of four bits each. With these values every ratio is reachable in a few hundred clocks, including the 256-state maximum. Each scenario measures three things from the ports:

- the delay from reset to the first pulse;
- the pulse width;
- the full period, together with the number of cycles in which `msb_out` is high during that period.

Taken together, these cover all four mode pairs, digit clamping, the all-zero and chain-disabled maxima, and the ratios at both ends of the range.

// File: rtl/divn_pkg.sv
package divn_pkg;
  // Counting mode of one digit.
  typedef enum logic {
    CNT_BIN = 1'b0,
    CNT_DEC = 1'b1
  } cnt_mode_e;

  // Highest value a decimal digit may hold.
  localparam int unsigned DEC_TOP = 9;
endpackage

// File: rtl/divn_digit.sv
module divn_digit
  import divn_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               dec_mode,
  input  logic               load,
  input  logic [DIGIT_W-1:0] load_val,
  input  logic               borrow_in,
  output logic [DIGIT_W-1:0] q,
  output logic [DIGIT_W-1:0] q_next,
  output logic               borrow_out
);
  localparam logic [DIGIT_W-1:0] BIN_TOP = {DIGIT_W{1'b1}};
  localparam logic [DIGIT_W-1:0] DEC_MAX = DIGIT_W'(DEC_TOP);

  cnt_mode_e          mode;
  logic [DIGIT_W-1:0] wrap_val;
  logic               at_zero;

  assign mode       = cnt_mode_e'(dec_mode);
  assign wrap_val   = (mode == CNT_DEC) ? DEC_MAX : BIN_TOP;
  assign at_zero    = (q == '0);
  assign borrow_out = borrow_in & at_zero;

  always_comb begin
    if (load)
      q_next = load_val;
    else if (borrow_in)
      q_next = at_zero ? wrap_val : (q - DIGIT_W'(1));
    else
      q_next = q;
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end
endmodule

// File: rtl/divn_load.sv
module divn_load
  import divn_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 2,
  localparam int CNT_W     = DIGIT_W * NUM_DIGITS
) (
  input  logic [CNT_W-1:0]      preset,
  input  logic [NUM_DIGITS-1:0] digit_dec,
  input  logic                  cascade_en,
  output logic [CNT_W-1:0]      load_val
);
  localparam logic [DIGIT_W-1:0] DEC_MAX = DIGIT_W'(DEC_TOP);

  logic [CNT_W-1:0] clamped;
  logic             force_max;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_clamp
    logic [DIGIT_W-1:0] raw;
    assign raw = preset[i*DIGIT_W +: DIGIT_W];
    assign clamped[i*DIGIT_W +: DIGIT_W] =
      (digit_dec[i] && (raw > DEC_MAX)) ? DEC_MAX : raw;
  end

  // An all-zero load wraps through every state: the maximum modulus.
  assign force_max = !cascade_en || (preset == '0);
  assign load_val  = force_max ? '0 : clamped;
endmodule

// File: rtl/divn_term.sv
module divn_term #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             term
);
  always_ff @(posedge clk) begin
    if (rst)
      term <= 1'b0;
    else
      term <= (cnt_next == CNT_W'(1));
  end
endmodule

// File: rtl/divn_counter.sv
module divn_counter #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 2,
  localparam int CNT_W     = DIGIT_W * NUM_DIGITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      preset,
  input  logic [NUM_DIGITS-1:0] digit_dec,
  input  logic                  cascade_en,
  output logic                  zero_pulse,
  output logic                  msb_out
);
  logic [CNT_W-1:0]    load_val;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cnt_next;
  logic [NUM_DIGITS:0] borrow;
  logic                reload;

  divn_load #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_load (
    .preset     (preset),
    .digit_dec  (digit_dec),
    .cascade_en (cascade_en),
    .load_val   (load_val)
  );

  // Reload at the edge that ends the count-of-one cycle, or on reset.
  assign reload    = rst | zero_pulse;
  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    divn_digit #(.DIGIT_W(DIGIT_W)) u_digit (
      .clk        (clk),
      .dec_mode   (digit_dec[i]),
      .load       (reload),
      .load_val   (load_val[i*DIGIT_W +: DIGIT_W]),
      .borrow_in  (borrow[i]),
      .q          (cnt[i*DIGIT_W +: DIGIT_W]),
      .q_next     (cnt_next[i*DIGIT_W +: DIGIT_W]),
      .borrow_out (borrow[i+1])
    );
  end

  divn_term #(.CNT_W(CNT_W)) u_term (
    .clk      (clk),
    .rst      (rst),
    .cnt_next (cnt_next),
    .term     (zero_pulse)
  );

  assign msb_out = cnt[CNT_W-1];
endmodule

// File: rtl/divn_counter_chk.sv
module divn_counter_chk #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 2,
  localparam int CNT_W     = DIGIT_W * NUM_DIGITS
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_DIGITS-1:0] digit_dec,
  input logic                  cascade_en,
  input logic                  zero_pulse,
  input logic [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]      load_val
);
  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !zero_pulse);

  // R3
  reload_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |=> cnt == $past(load_val));

  // R3
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_pulse && load_val != CNT_W'(1)) |=> !zero_pulse);

  // R1
  count_moves_chk: assert property (@(posedge clk) disable iff (rst)
    !zero_pulse |=> cnt != $past(cnt));

  // R7
  dec_low_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_pulse && digit_dec[0]) |=> cnt[DIGIT_W-1:0] <= DIGIT_W'(9));

  // R5
  chain_off_max_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_pulse && !cascade_en) |=> cnt == '0);
endmodule

bind divn_counter divn_counter_chk #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .digit_dec  (digit_dec),
  .cascade_en (cascade_en),
  .zero_pulse (zero_pulse),
  .cnt        (cnt),
  .load_val   (load_val)
);

// File: tb/divn_counter_bench.sv
module divn_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] preset = 8'h02;
  logic [1:0] digit_dec = 2'b00;
  logic       cascade_en = 1'b1;
  logic       zero_pulse;
  logic       msb_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  divn_counter u_divn_counter (
    .clk        (clk),
    .rst        (rst),
    .preset     (preset),
    .digit_dec  (digit_dec),
    .cascade_en (cascade_en),
    .zero_pulse (zero_pulse),
    .msb_out    (msb_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reset, then measure first-pulse latency, width, period and msb duty.
  task automatic run_case(input string tag, input logic [7:0] p, input logic [1:0] dm,
                          input logic ce, input int exp_n, input int exp_msb);
    int t;
    int per;
    int m;
    int width_low;
    @(negedge clk);
    preset = p; digit_dec = dm; cascade_en = ce; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!zero_pulse && t < 600);
    check(tag, "first pulse latency", t, exp_n - 1);
    @(negedge clk);
    per = 1;
    m = int'(msb_out);
    width_low = int'(!zero_pulse);
    while (!zero_pulse && per < 600) begin
      @(negedge clk);
      per++;
      m += int'(msb_out);
    end
    check(tag, "pulse width one cycle", width_low, 1);
    check(tag, "period", per, exp_n);
    if (exp_msb >= 0) check(tag, "msb_out high cycles", m, exp_msb);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    preset = 8'h80; digit_dec = 2'b00; cascade_en = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "zero_pulse held low in reset", int'(zero_pulse), 0);
    check("R8", "preset loaded in reset", int'(msb_out), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "count left preset after reset", int'(msb_out), 0);
  endtask

  task automatic t_limits;
    run_case("R9", 8'h02, 2'b00, 1'b1, 2, 0);
    run_case("R9", 8'h03, 2'b00, 1'b1, 3, 0);
    run_case("R9", 8'hFF, 2'b00, 1'b1, 255, 128);
  endtask

  task automatic t_zero_preset;
    run_case("R4", 8'h00, 2'b00, 1'b1, 256, 128);
    run_case("R4", 8'h00, 2'b11, 1'b1, 100, 20);
    run_case("R4", 8'h00, 2'b01, 1'b1, 160, 80);
    run_case("R4", 8'h00, 2'b10, 1'b1, 160, 32);
  endtask

  task automatic t_chain_off;
    run_case("R5", 8'h05, 2'b00, 1'b0, 256, 128);
    run_case("R5", 8'h37, 2'b11, 1'b0, 100, 20);
    run_case("R5", 8'h12, 2'b10, 1'b0, 160, 32);
  endtask

  task automatic t_modes;
    run_case("R2", 8'h25, 2'b01, 1'b1, 25, 0);
    run_case("R2", 8'h3A, 2'b10, 1'b1, 58, 0);
    run_case("R2", 8'h99, 2'b11, 1'b1, 99, 20);
    run_case("R1", 8'h47, 2'b00, 1'b1, 71, 0);
  endtask

  task automatic t_clamp;
    run_case("R7", 8'h1F, 2'b01, 1'b1, 19, 0);
    run_case("R7", 8'hC3, 2'b11, 1'b1, 93, 14);
  endtask

  task automatic t_msb;
    run_case("R6", 8'h90, 2'b00, 1'b1, 144, 17);
    run_case("R6", 8'h75, 2'b00, 1'b1, 117, 0);
  endtask

  initial begin
    t_reset_state();
    t_limits();
    t_zero_preset();
    t_chain_off();
    t_modes();
    t_clamp();
    t_msb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule